// File: doc/BRIEF.md
# SAR Converter Digital Control Core

This block is the digital half of a 12-bit successive-approximation converter. An active-low start pin begins a conversion whose length is timed by a counter on the internal oscillator clock. At the end of the conversion, the block stores the code supplied by the comparator path. It then samples two pins to choose its next mode. The start pin's level picks normal operation or power-down. The select pin's level picks whether the serial output announces completion by driving low.

A host reads the stored code over a three-wire serial link: an active-low select, a serial clock and a three-state data line. The data line is modelled as a data bit plus an output enable. The code is straight binary, sent most significant bit first, with each new bit placed on a falling serial-clock edge.

If the host raises select partway through a read, a deferred software reset is armed. That reset clears the stored code and the modes at the end of the next conversion. All three pins are taken into the oscillator clock domain through two-flop synchronizers before any edge is acted on.

Top module: `sar_ctrl_core`

## Requirements
- R1: A falling edge on `convst_ni` while idle starts a conversion; `converting_o` stays high for exactly CONV_CYCLES clock cycles, and the code on `result_i` at its end becomes the stored result.
- R2: At the end of a conversion, a low `convst_ni` level sets `pwr_down_o`; a high level leaves the block in normal mode with `pwr_down_o` low.
- R3: In power-down, a rising edge on `convst_ni` clears `pwr_down_o` and raises `powering_up_o` for PWRUP_CYCLES cycles; after that, a new conversion is accepted and returns a valid code.
- R4: If `cs_ni` is low at the end of a conversion, `busy_mode_o` goes high and SDO is driven low (`sdo_oe_o`=1, `sdo_o`=0) until the first serial-clock falling edge; a conversion ending with `cs_ni` high clears `busy_mode_o`.
- R5: In a read announced by R4, falling serial-clock edges 1 to 12 place bits 11 down to 0 of the stored code on `sdo_o`, and the 13th falling edge releases the line (`sdo_oe_o`=0).
- R6: Otherwise, a falling edge on `cs_ni` drives bit 11 onto `sdo_o`; falling serial-clock edges 1 to 11 place bits 10 down to 0, and the 12th releases the line.
- R7: A rising edge on `cs_ni` always releases SDO (`sdo_oe_o`=0), whatever the bit position.
- R8: Raising `cs_ni` after at least 2 and at most 7 falling serial-clock edges of a read sets `reset_armed_o`. A release after 1, or after 8 or more, edges does not. At the end of the next conversion, the armed reset clears the stored code to zero, forces normal mode even if `convst_ni` is low, clears busy mode, and drops `reset_armed_o`.
- R9: A falling edge on `convst_ni` during a conversion or during power-up is ignored (the running timing is unchanged) and produces a one-cycle pulse on `proto_err_o`.
- R10: The serial read of R6 works in power-down and returns the code stored by the conversion that entered it.
- R11: After reset, `sdo_oe_o`, `busy_mode_o`, `pwr_down_o`, `converting_o`, `powering_up_o`, `proto_err_o` and `reset_armed_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| convst_ni | input | 1 | Conversion start pin, active low, asynchronous |
| cs_ni | input | 1 | Serial select pin, active low, asynchronous |
| sclk_i | input | 1 | Serial clock pin, idles high, asynchronous |
| result_i | input | DATA_W | Code from the comparator path |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Serial data output enable (0 = high impedance) |
| busy_mode_o | output | 1 | Completion-announce mode active |
| pwr_down_o | output | 1 | Power-down mode active |
| converting_o | output | 1 | Conversion in progress (sampler in hold) |
| powering_up_o | output | 1 | Power-up interval running |
| proto_err_o | output | 1 | One-cycle pulse on an ignored start edge |
| reset_armed_o | output | 1 | Deferred software reset pending |

## Verification
Every pin change reaches internal state two clock edges after it is sampled, and the output registers update on the edge after that. So SDO is due about three cycles after a serial-clock or select edge. The bench holds each serial-clock phase for four cycles and compares the pin just before the next phase begins. Mode flags are due CONV_CYCLES plus about three cycles after the start edge, and the bench reads them ten cycles past that point. For the ignored-start case, the bench samples `converting_o` at a moment when a wrongly accepted second start would still hold it high, but the first conversion has already finished.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_PDOWN = 2'd2,
    ST_PWRUP = 2'd3
  } conv_st_e;
endpackage

// File: rtl/sar_pin_sync.sv
`timescale 1ns/1ps
module sar_pin_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] dly_o
);
  logic [N-1:0] ff1_q, ff2_q, ff3_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // pins idle high; reset to idle so no edge appears on release
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q[i] <= 1'b1;
        ff2_q[i] <= 1'b1;
        ff3_q[i] <= 1'b1;
      end else begin
        ff1_q[i] <= pin_i[i];
        ff2_q[i] <= ff1_q[i];
        ff3_q[i] <= ff2_q[i];
      end
    end
  end

  assign lvl_o = ff2_q;
  assign dly_o = ff3_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W       = 12,
  parameter int CONV_CYCLES  = 65,
  parameter int PWRUP_CYCLES = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cv_lvl_i,
  input  logic              cv_fall_i,
  input  logic              cv_rise_i,
  input  logic              cs_lvl_i,
  input  logic              arm_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] res_o,
  output logic              eoc_o,
  output logic              busy_mode_o,
  output logic              pwr_down_o,
  output logic              converting_o,
  output logic              powering_up_o,
  output logic              proto_err_o,
  output logic              armed_o
);
  localparam int MAX_CYC = (CONV_CYCLES > PWRUP_CYCLES) ? CONV_CYCLES : PWRUP_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] PWRUP_LAST = CNT_W'(PWRUP_CYCLES - 1);

  conv_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] res_q;
  logic              eoc_q, busy_q, err_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      res_q   <= '0;
      eoc_q   <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      err_q <= 1'b0;
      if (arm_i) armed_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (cv_fall_i) begin
            st_q  <= ST_CONV;
            cnt_q <= '0;
          end
        end
        ST_CONV: begin
          if (cv_fall_i) err_q <= 1'b1;
          if (cnt_q == CONV_LAST) begin
            eoc_q <= 1'b1;
            if (armed_q) begin
              // deferred reset: discard code, force normal mode
              res_q   <= '0;
              busy_q  <= 1'b0;
              armed_q <= 1'b0;
              st_q    <= ST_IDLE;
            end else begin
              res_q  <= result_i;
              busy_q <= ~cs_lvl_i;
              st_q   <= cv_lvl_i ? ST_IDLE : ST_PDOWN;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PDOWN: begin
          if (cv_rise_i) begin
            st_q  <= ST_PWRUP;
            cnt_q <= '0;
          end
        end
        ST_PWRUP: begin
          if (cv_fall_i) err_q <= 1'b1;
          if (cnt_q == PWRUP_LAST) st_q <= ST_IDLE;
          else                     cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign res_o         = res_q;
  assign eoc_o         = eoc_q;
  assign busy_mode_o   = busy_q;
  assign pwr_down_o    = (st_q == ST_PDOWN);
  assign converting_o  = (st_q == ST_CONV);
  assign powering_up_o = (st_q == ST_PWRUP);
  assign proto_err_o   = err_q;
  assign armed_o       = armed_q;
endmodule

// File: rtl/sar_shift_out.sv
`timescale 1ns/1ps
module sar_shift_out #(
  parameter int DATA_W    = 12,
  parameter int ABORT_MIN = 2,
  parameter int ABORT_MAX = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_lvl_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_fall_i,
  input  logic              eoc_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] res_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              arm_o
);
  localparam int CW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] A_MIN = CW'(ABORT_MIN);
  localparam logic [CW-1:0] A_MAX = CW'(ABORT_MAX);

  logic [DATA_W-1:0] shreg_q;
  logic [CW-1:0]     left_q;
  logic [CW-1:0]     fcnt_q;
  logic              sdo_q, oe_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      left_q  <= '0;
      fcnt_q  <= '0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      arm_q <= 1'b0;
      if (cs_rise_i) begin
        oe_q <= 1'b0;
        if (fcnt_q >= A_MIN && fcnt_q <= A_MAX) arm_q <= 1'b1;
      end else if (eoc_i && busy_i && !cs_lvl_i) begin
        // announce completion: hold low, all bits still to send
        shreg_q <= res_i;
        left_q  <= CW'(DATA_W);
        sdo_q   <= 1'b0;
        oe_q    <= 1'b1;
        fcnt_q  <= '0;
      end else if (cs_fall_i) begin
        shreg_q <= {res_i[DATA_W-2:0], 1'b0};
        left_q  <= CW'(DATA_W - 1);
        sdo_q   <= res_i[DATA_W-1];
        oe_q    <= 1'b1;
        fcnt_q  <= '0;
      end else if (sclk_fall_i && !cs_lvl_i) begin
        if (fcnt_q != '1) fcnt_q <= fcnt_q + 1'b1;
        if (oe_q) begin
          if (left_q == '0) begin
            oe_q <= 1'b0;
          end else begin
            sdo_q   <= shreg_q[DATA_W-1];
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            left_q  <= left_q - 1'b1;
          end
        end
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;
  assign arm_o    = arm_q;
endmodule

// File: rtl/sar_ctrl_core.sv
`timescale 1ns/1ps
module sar_ctrl_core #(
  parameter int DATA_W       = 12,
  parameter int CONV_CYCLES  = 65,
  parameter int PWRUP_CYCLES = 10000,
  parameter int ABORT_MIN    = 2,
  parameter int ABORT_MAX    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              convst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_mode_o,
  output logic              pwr_down_o,
  output logic              converting_o,
  output logic              powering_up_o,
  output logic              proto_err_o,
  output logic              reset_armed_o
);
  localparam int PIN_CV = 0;
  localparam int PIN_CS = 1;
  localparam int PIN_CK = 2;

  logic [2:0]        pin_lvl, pin_dly;
  logic              cv_fall, cv_rise, cs_fall, cs_rise, ck_fall;
  logic              arm, eoc, busy;
  logic [DATA_W-1:0] res;

  sar_pin_sync #(.N(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({sclk_i, cs_ni, convst_ni}),
    .lvl_o  (pin_lvl),
    .dly_o  (pin_dly)
  );

  assign cv_fall = pin_dly[PIN_CV] & ~pin_lvl[PIN_CV];
  assign cv_rise = ~pin_dly[PIN_CV] & pin_lvl[PIN_CV];
  assign cs_fall = pin_dly[PIN_CS] & ~pin_lvl[PIN_CS];
  assign cs_rise = ~pin_dly[PIN_CS] & pin_lvl[PIN_CS];
  assign ck_fall = pin_dly[PIN_CK] & ~pin_lvl[PIN_CK];

  sar_conv_ctrl #(
    .DATA_W       (DATA_W),
    .CONV_CYCLES  (CONV_CYCLES),
    .PWRUP_CYCLES (PWRUP_CYCLES)
  ) u_conv (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cv_lvl_i      (pin_lvl[PIN_CV]),
    .cv_fall_i     (cv_fall),
    .cv_rise_i     (cv_rise),
    .cs_lvl_i      (pin_lvl[PIN_CS]),
    .arm_i         (arm),
    .result_i      (result_i),
    .res_o         (res),
    .eoc_o         (eoc),
    .busy_mode_o   (busy),
    .pwr_down_o    (pwr_down_o),
    .converting_o  (converting_o),
    .powering_up_o (powering_up_o),
    .proto_err_o   (proto_err_o),
    .armed_o       (reset_armed_o)
  );

  sar_shift_out #(
    .DATA_W    (DATA_W),
    .ABORT_MIN (ABORT_MIN),
    .ABORT_MAX (ABORT_MAX)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_lvl_i    (pin_lvl[PIN_CS]),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .sclk_fall_i (ck_fall),
    .eoc_i       (eoc),
    .busy_i      (busy),
    .res_i       (res),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .arm_o       (arm)
  );

  assign busy_mode_o = busy;
endmodule

// File: rtl/sar_ctrl_core_chk.sv
`timescale 1ns/1ps
module sar_ctrl_core_chk #(
  parameter int CONV_CYCLES = 65
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sdo_oe_o,
  input logic pwr_down_o,
  input logic converting_o,
  input logic powering_up_o,
  input logic proto_err_o,
  input logic reset_armed_o
);
  logic [31:0] conv_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           conv_len_q <= '0;
    else if (converting_o) conv_len_q <= conv_len_q + 1;
    else                   conv_len_q <= '0;
  end

  a_r1_conv_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(converting_o) |-> conv_len_q == 32'(CONV_CYCLES));

  a_r2_pd_after_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_down_o) |-> $past(converting_o));

  a_r3_pwrup_from_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(powering_up_o) |-> $past(pwr_down_o));

  a_r7_cs_high_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) && $past(cs_ni, 4))
      |-> !sdo_oe_o);

  a_r8_disarm_at_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_armed_o) |-> $past(converting_o));

  a_r9_err_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> $past(converting_o || powering_up_o));
endmodule

bind sar_ctrl_core sar_ctrl_core_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_ni         (cs_ni),
  .sdo_oe_o      (sdo_oe_o),
  .pwr_down_o    (pwr_down_o),
  .converting_o  (converting_o),
  .powering_up_o (powering_up_o),
  .proto_err_o   (proto_err_o),
  .reset_armed_o (reset_armed_o)
);

// File: tb/sar_ctrl_core_bench.sv
`timescale 1ns/1ps
module sar_ctrl_core_bench;
  localparam int W     = 12;
  localparam int CONV  = 65;
  localparam int PWRUP = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convst_n = 1'b1, cs_n = 1'b1, sclk = 1'b1;
  logic [W-1:0] res = '0;
  logic sdo, sdo_oe, busy_m, pd, conv, pwrup, perr, armed;

  always #5 clk = ~clk;

  sar_ctrl_core u_sar_ctrl_core (
    .clk_i (clk), .rst_ni (rst_n), .convst_ni (convst_n), .cs_ni (cs_n),
    .sclk_i (sclk), .result_i (res), .sdo_o (sdo), .sdo_oe_o (sdo_oe),
    .busy_mode_o (busy_m), .pwr_down_o (pd), .converting_o (conv),
    .powering_up_o (pwrup), .proto_err_o (perr), .reset_armed_o (armed)
  );

  int checks = 0, errors = 0, err_pulses = 0;
  bit done = 1'b0;

  typedef struct { logic oe; logic d; string req; } exp_t;
  exp_t sbq[$];
  event smp;

  always @(negedge clk) if (rst_n && perr) err_pulses++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic oe, input logic d, input string req);
    exp_t e;
    e.oe = oe; e.d = d; e.req = req;
    sbq.push_back(e);
    -> smp;
    #1;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(smp);
      if (sbq.size() != 0) begin
        e = sbq.pop_front();
        checks++;
        if (sdo_oe !== e.oe || (e.oe && sdo !== e.d)) begin
          errors++;
          $display("FAIL %s sdo actual oe=%b d=%b expected oe=%b d=%b",
                   e.req, sdo_oe, sdo, e.oe, e.d);
        end
      end
    end
  end

  task automatic convert(input logic [W-1:0] v, input bit cs_low, input bit stay_low);
    res = v;
    if (cs_low) begin cs_n = 1'b0; cyc(6); end
    convst_n = 1'b0;
    cyc(10);
    if (!stay_low) convst_n = 1'b1;
    cyc(CONV + 10);
  endtask

  task automatic read_plain(input logic [W-1:0] v, input int nfalls, input string req);
    cs_n = 1'b0;
    cyc(6);
    push_exp(1'b1, v[W-1], req);
    for (int i = 1; i <= nfalls; i++) begin
      sclk = 1'b0;
      cyc(4);
      if (i <= W-1) push_exp(1'b1, v[W-1-i], req);
      else          push_exp(1'b0, 1'b0, req);
      sclk = 1'b1;
      cyc(4);
    end
    cs_n = 1'b1;
    cyc(6);
    push_exp(1'b0, 1'b0, "R7");
  endtask

  task automatic read_busy(input logic [W-1:0] v);
    push_exp(1'b1, 1'b0, "R4");
    for (int i = 1; i <= W+1; i++) begin
      sclk = 1'b0;
      cyc(4);
      if (i <= W) push_exp(1'b1, v[W-i], "R5");
      else        push_exp(1'b0, 1'b0, "R5");
      sclk = 1'b1;
      cyc(4);
    end
    cs_n = 1'b1;
    cyc(6);
    push_exp(1'b0, 1'b0, "R7");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    int e0;
    cyc(4);
    // R11 reset state
    chk("R11 oe", {31'd0, sdo_oe}, 0);
    chk("R11 flags", {26'd0, busy_m, pd, conv, pwrup, perr, armed}, 0);
    rst_n = 1'b1;
    cyc(5);

    // R1/R2/R6 normal conversion and read
    convert(12'hA5C, 1'b0, 1'b0);
    chk("R2 normal", {31'd0, pd}, 0);
    chk("R4 busy off", {31'd0, busy_m}, 0);
    read_plain(12'hA5C, 12, "R6");

    // R4/R5 announce mode
    convert(12'h3F1, 1'b1, 1'b0);
    chk("R4 busy on", {31'd0, busy_m}, 1);
    read_busy(12'h3F1);

    // R7 release mid-word; R8 edges outside window do not arm
    read_plain(12'h3F1, 9, "R7");
    chk("R8 no arm 9", {31'd0, armed}, 0);
    read_plain(12'h3F1, 1, "R7");
    chk("R8 no arm 1", {31'd0, armed}, 0);
    read_plain(12'h3F1, 3, "R8");
    chk("R8 armed", {31'd0, armed}, 1);

    // R8 deferred reset: code cleared, normal mode forced despite low start pin
    convert(12'h777, 1'b0, 1'b1);
    chk("R8 disarmed", {31'd0, armed}, 0);
    chk("R8 forced normal", {31'd0, pd}, 0);
    chk("R8 busy cleared", {31'd0, busy_m}, 0);
    convst_n = 1'b1;
    cyc(10);
    read_plain(12'h000, 12, "R8");

    // R9 second start during conversion ignored
    e0 = err_pulses;
    res = 12'h123;
    convst_n = 1'b0; cyc(10);
    convst_n = 1'b1; cyc(10);
    chk("R1 converting", {31'd0, conv}, 1);
    convst_n = 1'b0; cyc(6);
    convst_n = 1'b1; cyc(49);
    chk("R9 timing kept", {31'd0, conv}, 0);
    chk("R9 err pulse", err_pulses - e0, 1);
    cyc(20);
    chk("R9 no restart", {31'd0, conv}, 0);
    read_plain(12'h123, 12, "R1");

    // R2/R10/R3 power-down, read, power-up
    convert(12'hC0F, 1'b0, 1'b1);
    chk("R2 power-down", {31'd0, pd}, 1);
    read_plain(12'hC0F, 12, "R10");
    convst_n = 1'b1;
    cyc(10);
    chk("R3 powering", {31'd0, pwrup}, 1);
    chk("R3 pd cleared", {31'd0, pd}, 0);
    e0 = err_pulses;
    convst_n = 1'b0; cyc(5);
    convst_n = 1'b1; cyc(5);
    chk("R9 err in pwrup", err_pulses - e0, 1);
    cyc(PWRUP);
    chk("R3 powered", {31'd0, pwrup}, 0);
    chk("R3 normal", {31'd0, pd}, 0);
    convert(12'h001, 1'b0, 1'b0);
    read_plain(12'h001, 12, "R3");
    read_plain(12'hFFF ^ 12'hFFE, 12, "R6");

    done = 1'b1;
    cyc(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule